// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block holds the interrupt state of every channel of a multi-channel DMA engine. Each channel sees two hardware event levels from its transfer logic: one for completion and one for abort. From these the unit builds four word-wide views per channel:

- **live:** the raw event levels as they are now.
- **pending:** the events, held until software clears them.
- **mask:** a read/write enable word chosen by software.
- **flagged:** the pending word gated by the mask, read-only.

Software reaches the views through a plain register port. A write is applied at the next clock edge. A read is combinational from the selected channel and view.

The flagged words of all channels are merged onto the interrupt outputs. Channels 0 and 1 share output 0. Every later channel k has output k-1 to itself. An interrupt handler on the shared output must therefore read the flagged view of both channels, because either one may have raised it.

There is no data stream here, so every pin is a plain level. A write lasts exactly one cycle while `reg_wr` is high, and there is no back-pressure.

Top module: `dma_irq_unit`

## Requirements
- R1: View select 0 (live) reads the current event inputs of the addressed channel, with the completion level in bit 1 and the abort level in bit 13. Writes to this view change no state.
- R2: A pending bit becomes 1 at the clock edge after its event level is seen high. It then stays 1 after the event drops, until software clears it.
- R3: Writing view select 1 (pending) clears each bit written as 1, from the next cycle. Bits written as 0 keep their value.
- R4: When an event level is high in the same cycle that software clears that pending bit, the bit stays 1.
- R5: View select 2 (mask) stores bits 1 and 13 of a write and returns them on read. It changes only when it is written.
- R6: View select 3 (flagged) reads the pending word ANDed with the mask word. Writes to this view change no state.
- R7: Output 0 is high exactly when the flagged word of channel 0 or of channel 1 is nonzero. Output k, for k of 1 or more, is high exactly when the flagged word of channel k+1 is nonzero. All outputs are levels.
- R8: After reset every pending and mask bit is 0, and every interrupt output is low.
- R9: All bits other than 1 and 13 read as 0 in every view, whatever was written.
- R10: The flagged view of channel 0 can read 0 while output 0 is high, when channel 1 raised it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_done | input | NUM_CH | Completion event level, one bit per channel |
| evt_abort | input | NUM_CH | Abort event level, one bit per channel |
| reg_wr | input | 1 | Write strobe, one write per high cycle |
| reg_ch | input | CH_W | Channel addressed by read and write |
| reg_sel | input | 2 | View select: 0 live, 1 pending, 2 mask, 3 flagged |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed view, combinational |
| irq_line | output | NUM_CH-1 | Merged interrupt levels |

## Verification
The assertions assume the following about the inputs:
- Event inputs and the write strobe are known values at every clock edge after reset.
- A clear write and an event that touch the same bit can arrive together. The set-priority check covers that case rather than excluding it.
- Reads of an unused channel number are never relied on.

The stimulus changes every input only on the falling edge. It always addresses one of the configured channels. Event pulses are kept sparse, so latched bits can be seen surviving cleared neighbours and zero-valued writes.

// File: rtl/dma_irq_pkg.sv
`timescale 1ns/1ps
package dma_irq_pkg;
  localparam int WORD_W    = 32;
  localparam int DONE_BIT  = 1;
  localparam int ABORT_BIT = 13;
  localparam logic [WORD_W-1:0] EVT_MASK =
    (WORD_W'(1) << DONE_BIT) | (WORD_W'(1) << ABORT_BIT);

  typedef enum logic [1:0] {
    VIEW_LIVE = 2'd0,
    VIEW_PEND = 2'd1,
    VIEW_MASK = 2'd2,
    VIEW_FLAG = 2'd3
  } view_e;

  function automatic logic [WORD_W-1:0] pack_events(input logic done, input logic abort);
    logic [WORD_W-1:0] w;
    w = '0;
    w[DONE_BIT]  = done;
    w[ABORT_BIT] = abort;
    return w;
  endfunction
endpackage

// File: rtl/dma_irq_chan.sv
`timescale 1ns/1ps
module dma_irq_chan
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_done,
  input  logic              evt_abort,
  input  logic              clr_we,
  input  logic              mask_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] live_o,
  output logic [WORD_W-1:0] pend_o,
  output logic [WORD_W-1:0] mask_o,
  output logic [WORD_W-1:0] flag_o,
  output logic              flag_any_o
);
  logic [WORD_W-1:0] live_w, clr_w, pend_q, mask_q;

  assign live_w = pack_events(evt_done, evt_abort);
  assign clr_w  = clr_we ? (wdata & EVT_MASK) : '0;

  // set has priority: new events are ORed after the clear is applied
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= ((pend_q & ~clr_w) | live_w) & EVT_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= wdata & EVT_MASK;
    end
  end

  assign live_o     = live_w;
  assign pend_o     = pend_q;
  assign mask_o     = mask_q;
  assign flag_o     = pend_q & mask_q;
  assign flag_any_o = |flag_o;

  assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> pend_q[DONE_BIT]);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[DONE_BIT] && !clr_we) |=> pend_q[DONE_BIT]);
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wdata[DONE_BIT] && !evt_done) |=> !pend_q[DONE_BIT]);
  assert_w0_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[ABORT_BIT] && clr_we && !wdata[ABORT_BIT]) |=> pend_q[ABORT_BIT]);
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wdata[ABORT_BIT] && evt_abort) |=> pend_q[ABORT_BIT]);
  assert_mask_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/dma_irq_merge.sv
`timescale 1ns/1ps
module dma_irq_merge #(
  parameter int NUM_CH    = 8,
  localparam int NUM_LINES = NUM_CH - 1
) (
  input  logic [NUM_CH-1:0]    flag_any,
  output logic [NUM_LINES-1:0] line_o
);
  // channels 0 and 1 share line 0; channel k>=2 owns line k-1
  assign line_o[0] = flag_any[0] | flag_any[1];

  generate
    for (genvar k = 1; k < NUM_LINES; k++) begin : g_own
      assign line_o[k] = flag_any[k+1];
    end
  endgenerate
endmodule

// File: rtl/dma_irq_unit.sv
`timescale 1ns/1ps
module dma_irq_unit
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int NUM_LINES = NUM_CH - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    evt_done,
  input  logic [NUM_CH-1:0]    evt_abort,
  input  logic                 reg_wr,
  input  logic [CH_W-1:0]      reg_ch,
  input  logic [1:0]           reg_sel,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic [NUM_LINES-1:0] irq_line
);
  logic [WORD_W-1:0] live_v [NUM_CH];
  logic [WORD_W-1:0] pend_v [NUM_CH];
  logic [WORD_W-1:0] mask_v [NUM_CH];
  logic [WORD_W-1:0] flag_v [NUM_CH];
  logic [NUM_CH-1:0] flag_any;
  logic [NUM_CH-1:0] clr_we, mask_we;
  view_e             sel;

  assign sel = view_e'(reg_sel);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign clr_we[c]  = reg_wr && (reg_ch == CH_W'(c)) && (sel == VIEW_PEND);
      assign mask_we[c] = reg_wr && (reg_ch == CH_W'(c)) && (sel == VIEW_MASK);

      dma_irq_chan u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_done   (evt_done[c]),
        .evt_abort  (evt_abort[c]),
        .clr_we     (clr_we[c]),
        .mask_we    (mask_we[c]),
        .wdata      (reg_wdata),
        .live_o     (live_v[c]),
        .pend_o     (pend_v[c]),
        .mask_o     (mask_v[c]),
        .flag_o     (flag_v[c]),
        .flag_any_o (flag_any[c])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    if (int'(reg_ch) < NUM_CH) begin
      case (sel)
        VIEW_LIVE: reg_rdata = live_v[reg_ch];
        VIEW_PEND: reg_rdata = pend_v[reg_ch];
        VIEW_MASK: reg_rdata = mask_v[reg_ch];
        default:   reg_rdata = flag_v[reg_ch];
      endcase
    end
  end

  dma_irq_merge #(.NUM_CH(NUM_CH)) u_merge (
    .flag_any (flag_any),
    .line_o   (irq_line)
  );

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~EVT_MASK) == '0);
  assert_shared_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_v[0] != '0 || flag_v[1] != '0) |-> irq_line[0]);
  assert_shared_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_v[0] == '0 && flag_v[1] == '0) |-> !irq_line[0]);
  assert_flag_in_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == VIEW_FLAG && int'(reg_ch) < NUM_CH) |-> ((reg_rdata & ~mask_v[reg_ch]) == '0));
endmodule

// File: tb/sim_dma_irq_unit.sv
`timescale 1ns/1ps
module sim_dma_irq_unit;
  localparam int NCH = 8;
  localparam int CHW = 3;
  localparam int NL  = NCH - 1;
  localparam logic [31:0] MSK = 32'h0000_2002;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  evt_done = '0, evt_abort = '0;
  logic            reg_wr = 1'b0;
  logic [CHW-1:0]  reg_ch = '0;
  logic [1:0]      reg_sel = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NL-1:0]   irq_line;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_pend [NCH];
  logic [31:0] m_mask [NCH];
  logic [31:0] last_rd;

  always #4 clk = ~clk;

  dma_irq_unit #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_done(evt_done), .evt_abort(evt_abort),
    .reg_wr(reg_wr), .reg_ch(reg_ch), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_line(irq_line)
  );

  function automatic logic [31:0] ev(input logic d, input logic a);
    return (32'(d) << 1) | (32'(a) << 13);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [NCH-1:0] d, input logic [NCH-1:0] a, input logic w,
                      input int ch, input int sel, input logic [31:0] wd);
    logic [31:0] exp_rd;
    logic [NL-1:0] exp_irq;
    string tag;
    evt_done = d; evt_abort = a; reg_wr = w;
    reg_ch = CHW'(ch); reg_sel = 2'(sel); reg_wdata = wd;
    #1;
    case (sel)
      0: begin exp_rd = ev(d[ch], a[ch]); tag = "R1 live"; end
      1: begin exp_rd = m_pend[ch]; tag = "R3 pending"; end
      2: begin exp_rd = m_mask[ch]; tag = "R5 mask"; end
      default: begin exp_rd = m_pend[ch] & m_mask[ch]; tag = "R6 flagged"; end
    endcase
    exp_irq = '0;
    exp_irq[0] = ((m_pend[0] & m_mask[0]) != 0) || ((m_pend[1] & m_mask[1]) != 0);
    for (int k = 1; k < NL; k++) exp_irq[k] = (m_pend[k+1] & m_mask[k+1]) != 0;
    last_rd = reg_rdata;
    chk(tag, reg_rdata, exp_rd);
    chk("R7 irq_line", 32'(irq_line), 32'(exp_irq));
    for (int c = 0; c < NCH; c++) begin
      logic [31:0] p;
      p = m_pend[c];
      if (w && ch == c && sel == 1) p = p & ~wd;
      m_pend[c] = (p | ev(d[c], a[c])) & MSK;
      if (w && ch == c && sel == 2) m_mask[c] = wd & MSK;
    end
    @(negedge clk);
  endtask

  task automatic peek(input int ch, input int sel, input string tag, input logic [31:0] exp);
    step('0, '0, 1'b0, ch, sel, 32'h0);
    chk(tag, last_rd, exp);
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] wd);
    step('0, '0, 1'b1, ch, sel, wd);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_pend[c] = '0; m_mask[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state of every view and line
    for (int c = 0; c < NCH; c++)
      for (int s = 1; s < 4; s++) peek(c, s, "R8 reset view", 32'h0);
    chk("R8 irq after reset", 32'(irq_line), 32'h0);

    // R1: live view tracks levels, write to it is ignored
    step(8'h04, 8'h04, 1'b0, 2, 0, 32'h0);
    chk("R1 live both events", last_rd, 32'h2002);
    wr(2, 0, 32'hFFFF_FFFF);
    peek(2, 0, "R1 live after write", 32'h0);
    // R2: latched after events dropped
    peek(2, 1, "R2 pending held", 32'h2002);
    // R6: writing the flagged view changes nothing
    wr(2, 3, 32'hFFFF_FFFF);
    peek(2, 1, "R6 flag write ignored", 32'h2002);
    // R3: write-zero keeps, write-one clears
    wr(2, 1, 32'h0);
    peek(2, 1, "R3 write zero keeps", 32'h2002);
    wr(2, 1, 32'h2);
    peek(2, 1, "R3 clear done bit", 32'h2000);
    wr(2, 1, 32'h2000);
    peek(2, 1, "R3 clear abort bit", 32'h0);
    // R4: set beats clear in same cycle
    step(8'h08, 8'h00, 1'b1, 3, 1, 32'h2);
    peek(3, 1, "R4 set wins", 32'h2);
    // R9/R5: only implemented bits store
    wr(3, 2, 32'hFFFF_FFFF);
    peek(3, 2, "R9 mask unused zero", 32'h2002);
    peek(3, 3, "R6 flagged", 32'h2);
    chk("R7 own line ch3", 32'(irq_line[2]), 32'h1);
    wr(3, 1, 32'hFFFF_FFFF);
    peek(3, 3, "R6 flagged cleared", 32'h0);
    chk("R7 own line low", 32'(irq_line[2]), 32'h0);
    // R10: shared line raised by partner channel
    wr(1, 2, 32'h2);
    step(8'h02, 8'h00, 1'b0, 0, 0, 32'h0);
    peek(0, 3, "R10 ch0 flagged zero", 32'h0);
    chk("R10 shared line high", 32'(irq_line[0]), 32'h1);
    wr(1, 1, 32'h2);
    peek(1, 3, "R7 partner cleared", 32'h0);
    chk("R7 shared line low", 32'(irq_line[0]), 32'h0);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [NCH-1:0] d, a;
      for (int c = 0; c < NCH; c++) begin
        d[c] = ($urandom % 10) == 0;
        a[c] = ($urandom % 14) == 0;
      end
      step(d, a, ($urandom % 3) == 0, int'($urandom % NCH), int'($urandom % 4),
           ((($urandom % 2) == 0) ? 32'hFFFF_FFFF : $urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule